// File: doc/BRIEF.md
# Grouped Level Interrupt Combiner

The block takes a bank of level-sensitive interrupt lines, 32 by default, and folds them into a small number of combined request lines for a primary interrupt controller. The lines are split into equal groups (four groups of eight by default). Each group drives one output that is high whenever any enabled line in that group is active. Group `g` owns lines `[8g+7:8g]`, so the group's bit mask is `0xFF << (8*g)`.

Software talks to the block through a plain strobe interface with one 32-bit data word. The enable mask cannot be overwritten as a whole. Writing to the set offset turns enables on, and writing to the clear offset turns them off. In both cases each written 1 acts on its bit, and each written 0 leaves its bit alone. The interrupt handler reads a status word to find which lines are requesting service. Sources are levels: a status bit follows its synchronised input for as long as the line is enabled, and there is nothing to acknowledge.

Each input passes through a two-stage synchroniser. Each group output is registered. An input edge therefore reaches the status word after two clock edges and reaches the group output one edge later.

Top module: `irq_group_combiner`

## Requirements
- R1: While reset is applied and after it is released, every enable bit is 0 and every group output is 0, even with all inputs held high.
- R2: A write to offset 0x0 sets each enable bit whose data bit is 1. Enable bits written as 0 keep their value.
- R3: A write to offset 0x4 clears each enable bit whose data bit is 1. Enable bits written as 0 keep their value.
- R4: A read of offset 0x0 or of offset 0x4 returns the current 32-bit enable mask.
- R5: A read of offset 0xC returns the status word. Status bit i is the synchronised input i ANDed with enable bit i. The bit follows the input level with no latching, so it returns to 0 when the input falls.
- R6: Group output g is high exactly when any status bit in `[8g+7:8g]` was high one clock earlier. Lines outside that range have no effect on it.
- R7: An input change that is stable before clock edge k is absent from the status word after edge k and present after edge k+1.
- R8: Reads of any other offset (0x8 and every offset above 0xC) return 0, and writes to them change no enable bit.
- R9: While the read strobe is low, the read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Level interrupt sources, asynchronous to clk |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the same cycle as rd_en |
| group_irq | output | 4 | Combined request, one bit per group |

## Verification
A corrupted enable bit shows up on the very next read of offset 0x0 or 0x4. If its source line is high, it also shows up one edge later as a group output that is wrong. A pipeline stage that is wrong or missing in the synchroniser moves status changes by one cycle, which a read placed cycle by cycle after an input edge can see. The bench keeps a behavioural model of the enable mask, the two-cycle input delay and the group outputs. It compares group_irq against that model on every clock, so any error in the OR reduction or in the group-to-bit mapping is visible within one cycle of the status change that exposes it.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned REG_ADDR_W = 4;

  localparam logic [REG_ADDR_W-1:0] OFS_EN_SET = 4'h0;
  localparam logic [REG_ADDR_W-1:0] OFS_EN_CLR = 4'h4;
  localparam logic [REG_ADDR_W-1:0] OFS_STATUS = 4'hC;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_SET,
    ACC_CLR,
    ACC_STATUS
  } reg_acc_e;

  function automatic reg_acc_e decode_offset(input logic [REG_ADDR_W-1:0] a);
    case (a)
      OFS_EN_SET: return ACC_SET;
      OFS_EN_CLR: return ACC_CLR;
      OFS_STATUS: return ACC_STATUS;
      default:    return ACC_NONE;
    endcase
  endfunction

  function automatic int unsigned lane_base(input int unsigned grp,
                                            input int unsigned lanes);
    return grp * lanes;
  endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;
  logic             warm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
      warm_q   <= 1'b0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
      warm_q   <= 1'b1;
    end
  end

  assign sync_out = stage2_q;

  // R7
  first_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm_q |-> stage1_q == $past(async_in));

  // R7
  second_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm_q |-> sync_out == $past(stage1_q));

endmodule

// File: rtl/irqc_enable_bank.sv
module irqc_enable_bank #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [WIDTH-1:0] wmask,
  output logic [WIDTH-1:0] en_q
);

  logic [WIDTH-1:0] en_next;

  always_comb begin
    en_next = en_q;
    if (set_we) en_next = en_q | wmask;
    else if (clr_we) en_next = en_q & ~wmask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_next;
  end

  // R2
  set_reaches_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((en_q & $past(wmask)) == $past(wmask)));

  // R2
  set_keeps_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((en_q & ~$past(wmask)) == ($past(en_q) & ~$past(wmask))));

  // R3
  clr_reaches_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((en_q & $past(wmask)) == '0));

  // R3
  clr_keeps_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((en_q & ~$past(wmask)) == ($past(en_q) & ~$past(wmask))));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(en_q));

  // R2
  one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_we && clr_we));

endmodule

// File: rtl/irqc_group_reduce.sv
module irqc_group_reduce #(
  parameter int unsigned GROUPS = 4,
  parameter int unsigned LANES  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [GROUPS*LANES-1:0]   status,
  output logic [GROUPS-1:0]         grp_q
);

  import irqc_pkg::*;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam int unsigned LO = lane_base(g, LANES);
    logic any_w;
    assign any_w = |status[LO +: LANES];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) grp_q[g] <= 1'b0;
      else        grp_q[g] <= any_w;
    end
  end

endmodule

// File: rtl/irq_group_combiner.sv
module irq_group_combiner #(
  parameter int unsigned GROUPS = 4,
  parameter int unsigned LANES  = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [GROUPS*LANES-1:0]          irq_in,
  input  logic                             wr_en,
  input  logic                             rd_en,
  input  logic [irqc_pkg::REG_ADDR_W-1:0]  addr,
  input  logic [GROUPS*LANES-1:0]          wdata,
  output logic [GROUPS*LANES-1:0]          rdata,
  output logic [GROUPS-1:0]                group_irq
);

  import irqc_pkg::*;

  localparam int unsigned NSRC = GROUPS * LANES;

  reg_acc_e          acc_w;
  logic              set_we_w;
  logic              clr_we_w;
  logic [NSRC-1:0]   sync_w;
  logic [NSRC-1:0]   en_w;
  logic [NSRC-1:0]   status_w;
  logic              warm_q;

  assign acc_w    = decode_offset(addr);
  assign set_we_w = wr_en && (acc_w == ACC_SET);
  assign clr_we_w = wr_en && (acc_w == ACC_CLR);

  irqc_sync #(.WIDTH(NSRC)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (irq_in),
    .sync_out (sync_w)
  );

  irqc_enable_bank #(.WIDTH(NSRC)) u_enable (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (set_we_w),
    .clr_we (clr_we_w),
    .wmask  (wdata),
    .en_q   (en_w)
  );

  assign status_w = sync_w & en_w;

  irqc_group_reduce #(.GROUPS(GROUPS), .LANES(LANES)) u_reduce (
    .clk    (clk),
    .rst_n  (rst_n),
    .status (status_w),
    .grp_q  (group_irq)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (acc_w)
        ACC_SET, ACC_CLR: rdata = en_w;
        ACC_STATUS:       rdata = status_w;
        default:          rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= 1'b0;
    else        warm_q <= 1'b1;
  end

  // R9
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == '0);

  // R8
  unused_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr != OFS_EN_SET && addr != OFS_EN_CLR && addr != OFS_STATUS)
      |-> rdata == '0);

  // R5
  status_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFS_STATUS) |-> ((rdata & ~en_w) == '0));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !warm_q |-> (group_irq == '0 && en_w == '0));

  for (genvar g = 0; g < GROUPS; g++) begin : g_chk
    localparam int unsigned LO = lane_base(g, LANES);
    // R6
    group_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      warm_q |-> group_irq[g] == (|$past(sync_w[LO +: LANES] & en_w[LO +: LANES])));
  end

endmodule

// File: tb/test_irq_group_combiner.sv
`timescale 1ns/1ps
module test_irq_group_combiner;

  localparam int GROUPS = 4;
  localparam int LANES  = 8;
  localparam int NSRC   = GROUPS * LANES;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NSRC-1:0] irq_in;
  logic            wr_en;
  logic            rd_en;
  logic [3:0]      addr;
  logic [NSRC-1:0] wdata;
  logic [NSRC-1:0] rdata;
  logic [GROUPS-1:0] group_irq;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [NSRC-1:0]   m_en = '0;
  logic [NSRC-1:0]   m_s1 = '0;
  logic [NSRC-1:0]   m_s2 = '0;
  logic [GROUPS-1:0] m_grp = '0;
  logic [31:0]       lfsr = 32'h1234_5678;

  always #2.5 clk = ~clk;

  irq_group_combiner #(.GROUPS(GROUPS), .LANES(LANES)) i_irq_group_combiner (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .group_irq (group_irq)
  );

  task automatic check(input string tag, input logic [NSRC-1:0] act,
                       input logic [NSRC-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural model, updated on every edge from the inputs only
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = '0; m_s1 = '0; m_s2 = '0; m_grp = '0;
    end else begin
      logic [GROUPS-1:0] g_next;
      g_next = '0;
      for (int i = 0; i < NSRC; i++)
        if (m_s2[i] && m_en[i]) g_next[i / LANES] = 1'b1;
      m_grp = g_next;
      m_s2 = m_s1;
      m_s1 = irq_in;
      if (wr_en && addr == 4'h0) m_en = m_en | wdata;
      if (wr_en && addr == 4'h4) m_en = m_en & ~wdata;
    end
  end

  // R6: group outputs against the model on every clock
  always @(negedge clk) begin
    if (rst_n === 1'b1)
      check("R6 group outputs", NSRC'(group_irq), NSRC'(m_grp));
  end

  function automatic logic [NSRC-1:0] model_read(input logic [3:0] a);
    if (a == 4'h0 || a == 4'h4) return m_en;
    if (a == 4'hC) return m_s2 & m_en;
    return '0;
  endfunction

  task automatic do_write(input logic [3:0] a, input logic [NSRC-1:0] d);
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic do_read(input logic [3:0] a, input string tag);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b1; addr = a;
    #0.5;
    check(tag, rdata, model_read(a));
    rd_en = 1'b0;
  endtask

  task automatic read_expect(input logic [3:0] a, input logic [NSRC-1:0] exp,
                             input string tag);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b1; addr = a;
    #0.5;
    check(tag, rdata, exp);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_in = '1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    check("R1 group during reset", NSRC'(group_irq), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 group after reset", NSRC'(group_irq), '0);
    read_expect(4'h0, '0, "R1 enable after reset");
    read_expect(4'hC, '0, "R1 status after reset");

    // R9: strobe low gives zero data
    @(negedge clk); rd_en = 1'b0; addr = 4'h0; #0.5;
    check("R9 idle read data", rdata, '0);

    // R2 / R4
    do_write(4'h0, 32'h0000_00FF);
    read_expect(4'h0, 32'h0000_00FF, "R2 set group0");
    do_write(4'h0, 32'h0F00_0000);
    read_expect(4'h4, 32'h0F00_00FF, "R2 set keeps others / R4 read at clear offset");
    // R3
    do_write(4'h4, 32'h0000_000F);
    read_expect(4'h0, 32'h0F00_00F0, "R3 clear low nibble");
    read_expect(4'hC, 32'h0F00_00F0, "R5 status with inputs high");
    repeat (2) @(negedge clk);
    check("R6 groups 0 and 3 high", NSRC'(group_irq), NSRC'(4'b1001));

    // R8: unused offsets
    do_write(4'h8, '1);
    do_write(4'hC, '1);
    do_write(4'hF, '1);
    read_expect(4'h4, 32'h0F00_00F0, "R8 unused writes ignored");
    read_expect(4'h8, '0, "R8 unused read 0x8");
    read_expect(4'hE, '0, "R8 unused read 0xE");

    // R7 / R5: two-edge input delay and level following
    do_write(4'h0, '1);
    @(negedge clk); irq_in = '0;
    repeat (3) @(negedge clk);
    check("R6 all groups low", NSRC'(group_irq), '0);
    irq_in = 32'h0000_00A5;
    read_expect(4'hC, '0, "R7 status after one edge");
    read_expect(4'hC, 32'h0000_00A5, "R7 status after two edges");
    @(negedge clk);
    check("R6 group0 after status", NSRC'(group_irq), NSRC'(4'b0001));
    irq_in = '0;
    repeat (2) @(negedge clk);
    read_expect(4'hC, '0, "R5 status follows falling level");
    irq_in = 32'h0080_0000;
    repeat (3) @(negedge clk);
    check("R6 group2 only", NSRC'(group_irq), NSRC'(4'b0100));
    do_write(4'h4, 32'h00FF_0000);
    @(negedge clk);
    check("R6 group2 masked", NSRC'(group_irq), '0);

    // mixed traffic against the model
    for (int k = 0; k < 600; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (lfsr[2:0])
        3'd0: do_write(4'h0, {lfsr[7:0], lfsr[31:8]} & {lfsr[15:0], lfsr[31:16]});
        3'd1: do_write(4'h4, {lfsr[11:0], lfsr[31:12]});
        3'd2: do_read(lfsr[6:3], "R4 R5 R8 mixed read");
        3'd3: do_read(4'hC, "R5 mixed status read");
        3'd4: do_write(lfsr[6:3], {lfsr[3:0], lfsr[31:4]});
        default: begin
          @(negedge clk);
          irq_in = {lfsr[19:0], lfsr[31:20]} & {lfsr[5:0], lfsr[31:6]};
        end
      endcase
    end

    repeat (3) @(negedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule